// File: doc/BRIEF.md
# Guarded Dual-Plane Page Writer

This block is the write controller for an 8K-byte memory. The memory is split into two planes of 4K bytes, and the top address bit chooses the plane. A host writes only after a fixed three-write unlock command. After the unlock it loads up to 32 bytes into one aligned 32-byte page. When the host stops writing for a set number of cycles, the page load closes and an internal write cycle begins. That cycle lasts a set number of cycles and then commits the loaded bytes to the array. The array is modelled as plain RAM.

The memory is also split into eight 1K blocks, each with its own lock bit. A byte aimed at a locked block is dropped. A write-control input blocks all writes while it is high. If it rises while a page is loading, the load is aborted. During the write cycle the other plane can still be read with normal data. A read of the busy plane returns a status byte whose bit 6 flips on every read, so software can poll for the end of the cycle.

Top module: `guarded_page_writer`

## Requirements
- R1: A read (`req`=1, `we`=0) raises `rvalid` on the next cycle, and `rdata` then holds the array byte at `addr`, except where R7 applies. `rvalid` is 0 after a cycle without a read.
- R2: A write reaches the array only after three consecutive writes: 0x1555/0xAA, then 0x0AAA/0x55, then 0x1555/0xA0. A wrong pair returns the sequencer to idle, and the writes that follow have no effect.
- R3: After the unlock, the first byte that is accepted fixes the 32-byte page, given by address bits [12:5]. Later bytes for any other page are dropped. A second byte to the same offset replaces the first.
- R4: The write cycle starts `TIMEOUT` cycles after the last accepted byte, when `busy` rises. `busy` stays high for `WR_CYCLES` cycles. After it falls, the array holds the loaded bytes.
- R5: `prot[k]`=1 locks block k, where k is address bits [12:10]. Bytes for a locked block are dropped. If no byte is accepted, no write cycle starts.
- R6: While `wc`=1, every write is ignored. If `wc` is 1 in any cycle of a page load, the load is aborted and nothing is written.
- R7: During the write cycle, a read of the busy plane returns 0x40 on the first read and alternates between 0x00 and 0x40 on later reads. Bits 7 and 5..0 read as 0.
- R8: During the write cycle, reads of the other plane return array data.
- R9: Writes that arrive during the write cycle, unlock writes included, have no effect.
- R10: After reset, `busy` and `rvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Byte address; bit 12 selects the plane |
| wdata | input | 8 | Write data |
| wc | input | 1 | Write control; high blocks and aborts writes |
| prot | input | 8 | Lock bit for each 1K block |
| rdata | output | 8 | Read data or status byte |
| rvalid | output | 1 | `rdata` is valid |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two functions can fall in the same cycle: status polling of the plane being written, and a normal array read of the other plane. The bench provokes this by mixing reads of both planes, plus a full unlock-and-write attempt, inside one write cycle. Each status read must match the expected alternating value. Each other-plane read must match the bench's memory model. After `busy` falls, the other plane must be unchanged and the busy plane must hold its new page.

// File: rtl/guarded_page_writer.sv
module guarded_page_writer #(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int PAGE      = 32,
  parameter int NBLK      = 8,
  parameter int TIMEOUT   = 64,
  parameter int WR_CYCLES = 200,
  parameter logic [AW-1:0] UA1 = 13'h1555,
  parameter logic [AW-1:0] UA2 = 13'h0AAA,
  parameter logic [DW-1:0] UD1 = 8'hAA,
  parameter logic [DW-1:0] UD2 = 8'h55,
  parameter logic [DW-1:0] UD3 = 8'hA0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wc,
  input  logic [NBLK-1:0] prot,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          busy
);
  localparam int PW = $clog2(PAGE);
  localparam int BW = $clog2(NBLK);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {IDLE, UNL1, UNL2, LOAD, PROG} st_t;
  st_t st;

  logic [DW-1:0]    mem  [2**AW];
  logic [DW-1:0]    pbuf [PAGE];
  logic [PAGE-1:0]  pmask;
  logic [AW-1:PW]   pbase;
  logic [TW-1:0]    tcnt;
  logic [CW-1:0]    pcnt;
  logic             tog;

  wire wr       = req & we & ~wc;
  wire rd       = req & ~we;
  wire locked   = prot[addr[AW-1 -: BW]];
  wire in_page  = ~|pmask | (addr[AW-1:PW] == pbase);
  wire take     = (st == LOAD) & wr & ~locked & in_page;
  wire stat_rd  = rd & (st == PROG) & (addr[AW-1] == pbase[AW-1]);
  wire commit   = (st == PROG) & (pcnt == CW'(WR_CYCLES - 1));
  wire m1       = (addr == UA1) & (wdata == UD1);
  wire m2       = (addr == UA2) & (wdata == UD2);
  wire m3       = (addr == UA1) & (wdata == UD3);
  wire busy_plane = pbase[AW-1];

  assign busy = (st == PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      pmask <= '0;
      pbase <= '0;
      tcnt  <= '0;
      pcnt  <= '0;
      tog   <= 1'b0;
    end else begin
      case (st)
        IDLE: if (wr && m1) st <= UNL1;
        UNL1: if (wr) st <= m2 ? UNL2 : IDLE;
        UNL2: if (wr) begin
          st    <= m3 ? LOAD : IDLE;
          pmask <= '0;
          tcnt  <= '0;
        end
        LOAD: begin
          if (wc) begin
            st    <= IDLE;
            pmask <= '0;
          end else if (take) begin
            pmask[addr[PW-1:0]] <= 1'b1;
            if (!(|pmask)) pbase <= addr[AW-1:PW];
            tcnt <= '0;
          end else if (tcnt == TW'(TIMEOUT - 1)) begin
            st   <= (|pmask) ? PROG : IDLE;
            pcnt <= '0;
            tog  <= 1'b0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PROG: begin
          if (stat_rd) tog <= ~tog;
          if (commit) begin
            st    <= IDLE;
            pmask <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (take) pbuf[addr[PW-1:0]] <= wdata;

  always_ff @(posedge clk)
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{pbase, i[PW-1:0]}] <= pbuf[i];

  always_ff @(posedge clk)
    if (rd) rdata <= stat_rd ? (tog ? '0 : DW'(1 << 6)) : mem[addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd;

endmodule

// File: rtl/guarded_page_writer_chk.sv
module guarded_page_writer_chk #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic          wc,
  input logic [DW-1:0] rdata,
  input logic          rvalid,
  input logic          busy,
  input logic          plane
);
  a_r1_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);

  a_r7_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req && !we && addr[AW-1] == plane) |=> (rdata[7] == 1'b0 && rdata[5:0] == 6'd0));

  a_r6_no_start_under_wc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wc));

  a_r9_plane_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(plane));

  a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy);
endmodule

bind guarded_page_writer guarded_page_writer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wc(wc),
  .rdata(rdata), .rvalid(rvalid), .busy(busy), .plane(busy_plane)
);

// File: tb/guarded_page_writer_bench.sv
module guarded_page_writer_bench;
  localparam int TO = 16;
  localparam int WCY = 40;

  logic clk = 0, rst_n = 0, req = 0, we = 0, wc = 0;
  logic [12:0] addr = '0;
  logic [7:0] wdata = '0, prot = '0, rdata;
  logic rvalid, busy;

  guarded_page_writer #(.TIMEOUT(TO), .WR_CYCLES(WCY)) u_guarded_page_writer (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .wc(wc), .prot(prot), .rdata(rdata), .rvalid(rvalid), .busy(busy));

  always #5 clk = ~clk;

  logic [7:0] exp_m [8192];
  bit known [8192];
  logic [7:0] pexp [32];
  bit pm [32];
  logic [7:0] rb;
  logic rvb;
  int n_chk = 0, n_bad = 0;

  function automatic logic [7:0] stat_exp(input int n);
    return (n % 2 == 0) ? 8'h40 : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] ex);
    n_chk++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [12:0] a);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    rb = rdata; rvb = rvalid;
    req = 0;
  endtask

  task automatic unlock();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
  endtask

  task automatic load_bytes(input logic [12:0] base, input int nb, input bit seq);
    for (int i = 0; i < 32; i++) pm[i] = 0;
    unlock();
    for (int i = 0; i < nb; i++) begin
      int off;
      logic [12:0] a;
      logic [7:0] d;
      off = seq ? i : int'($urandom % 32);
      a = {base[12:5], 5'(off)};
      d = 8'($urandom);
      wr(a, d);
      if (!prot[a[12:10]]) begin pm[off] = 1; pexp[off] = d; end
    end
  endtask

  function automatic bit any_pm();
    for (int i = 0; i < 32; i++) if (pm[i]) return 1;
    return 0;
  endfunction

  task automatic commit_model(input logic [12:0] base);
    for (int i = 0; i < 32; i++)
      if (pm[i]) begin
        exp_m[{base[12:5], 5'(i)}] = pexp[i];
        known[{base[12:5], 5'(i)}] = 1;
      end
  endtask

  task automatic finish_timed(input logic [12:0] base);
    bit any;
    any = any_pm();
    idle(TO - 1); chk("R4 busy low before timeout", busy, 0);
    idle(1);      chk("R4/R5 busy at timeout", busy, any);
    if (any) begin
      idle(WCY - 1); chk("R4 busy through cycle", busy, 1);
      idle(1);       chk("R4 busy falls", busy, 0);
    end
    commit_model(base);
  endtask

  task automatic verify(input string tag, input logic [12:0] base);
    for (int i = 0; i < 32; i++) begin
      logic [12:0] a;
      a = {base[12:5], 5'(i)};
      if (known[a]) begin
        rd(a);
        chk(tag, {rvb, rb}, {1'b1, exp_m[a]});
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] p0, p1, a;
    int ns;
    void'($urandom(32'd1234));
    p0 = 13'h0040; p1 = 13'h1080;
    idle(3);
    chk("R10 busy after reset", busy, 0);
    chk("R10 rvalid after reset", rvalid, 0);
    rst_n = 1;
    idle(1);

    load_bytes(p0, 32, 1); finish_timed(p0); verify("R4 page p0", p0);
    load_bytes(p1, 32, 1); finish_timed(p1); verify("R1 page p1", p1);
    idle(1); chk("R1 rvalid low after no read", rvalid, 0);

    a = p0 + 5;
    wr(a, ~exp_m[a]); idle(TO + 2);
    chk("R2 no write without unlock busy", busy, 0);
    rd(a); chk("R2 data kept without unlock", rb, exp_m[a]);

    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h56); wr(13'h1555, 8'hA0); wr(a, ~exp_m[a]);
    idle(TO + 2);
    chk("R2 bad sequence busy", busy, 0);
    rd(a); chk("R2 data kept after bad sequence", rb, exp_m[a]);

    for (int i = 0; i < 32; i++) pm[i] = 0;
    unlock();
    wr(p0 + 3, 8'h3C); pm[3] = 1; pexp[3] = 8'h11;
    wr(p1 + 7, 8'hC3);
    wr(p0 + 3, 8'h11);
    finish_timed(p0);
    rd(p0 + 3); chk("R3 same offset replaced", rb, 8'h11);
    rd(p1 + 7); chk("R3 out-of-page byte dropped", rb, exp_m[p1 + 7]);

    prot = 8'h01;
    load_bytes(p0, 6, 1);
    chk("R5 locked bytes give no page", any_pm(), 0);
    finish_timed(p0);
    verify("R5 locked block unchanged", p0);
    prot = 8'h00;

    for (int i = 0; i < 32; i++) pm[i] = 0;
    unlock(); wr(p0 + 9, ~exp_m[p0 + 9]);
    wc = 1; idle(1); wc = 0;
    idle(TO + 2); chk("R6 abort busy", busy, 0);
    rd(p0 + 9); chk("R6 aborted load unchanged", rb, exp_m[p0 + 9]);
    wc = 1; unlock(); wr(p0 + 9, ~exp_m[p0 + 9]); wc = 0;
    idle(TO + 2); chk("R6 writes ignored under wc", busy, 0);
    rd(p0 + 9); chk("R6 data kept under wc", rb, exp_m[p0 + 9]);

    load_bytes(p1, 20, 0);
    idle(TO); chk("R4 busy at start of concurrent cycle", busy, 1);
    ns = 0;
    rd(p0 + 1);  chk("R8 other plane read", rb, exp_m[p0 + 1]);
    rd(p1 + 2);  chk("R7 status read 1", rb, stat_exp(ns)); ns++;
    rd(p1 + 30); chk("R7 status read 2", rb, stat_exp(ns)); ns++;
    unlock(); wr(p0 + 12, ~exp_m[p0 + 12]);
    rd(p0 + 12); chk("R8 other plane read after blocked write", rb, exp_m[p0 + 12]);
    rd(p1);      chk("R7 status read 3", rb, stat_exp(ns)); ns++;
    for (int k = 0; k < WCY && busy; k++) idle(1);
    chk("R4 concurrent cycle ends", busy, 0);
    commit_model(p1);
    idle(TO + 2); chk("R9 no stray write cycle", busy, 0);
    verify("R9 plane0 untouched", p0);
    verify("R8 plane1 committed", p1);

    for (int it = 0; it < 20; it++) begin
      logic [12:0] b;
      b = {8'($urandom), 5'd0};
      prot = 8'($urandom) & 8'($urandom);
      load_bytes(b, 1 + int'($urandom % 32), 0);
      finish_timed(b);
      prot = 8'h00;
      verify("R5 random page", b);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule